// File: doc/BRIEF.md
# Speaker Tone Control Unit

This block produces the one-bit drive for a small speaker and gives software three ways to make sound with it, which may all be used together. Software can flip a speaker-enable bit by hand to make a pulse train. A 16-bit down-counter can make a square wave. A second control bit gates that counter's clock, so software can start, stop and modulate the tone.

Software reaches the block through a one-cycle write port. A select line chooses between the control register and the reload register. The counter advances only on cycles where the external count enable is high, so it can run from a slower tick than the system clock. The speaker bit is the tone waveform ANDed with the enable bit. While the gate is low the tone is held high, and the enable bit alone then drives the speaker.

Top module: `spk_tone_ctrl`

## Requirements
- R1: After reset `spk_out` is low, the gate bit and the enable bit are clear, and the tone is high. Setting only the enable bit then drives `spk_out` high.
- R2: A write with `wr_sel`=0 loads the control register: `wr_data[0]` is the gate and `wr_data[1]` is the speaker enable. A write with `wr_sel`=1 loads `wr_data[15:0]` as the reload value. Register changes show at the outputs the cycle after the write edge.
- R3: `spk_out` is high exactly when the tone is high and the enable bit is set. With the enable bit clear, `spk_out` stays low while the counter runs.
- R4: While the gate is low, the tone is forced high from the next edge and the count does not change.
- R5: A control write that moves the gate from 0 to 1 arms a restart. At the next edge the count is loaded with the reload value and the tone is set high. Counting starts on the edge after that.
- R6: With the gate high and no restart pending, each edge with `cnt_ce` high decrements the count. When the count is 1, the tone toggles and the count reloads instead. A reload value N therefore gives N enabled ticks per half-period and 2N per full period.
- R7: Edges with `cnt_ce` low leave the count and the tone unchanged.
- R8: A new reload value is used only at the next reload point (terminal count or restart). The half-period in progress runs to its end.
- R9: A reload value of 0 counts as 65536 ticks per half-period.
- R10: Manual enable toggling, the tone and gate modulation may all act at the same time, and `spk_out` always follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 1 | 0 = control register, 1 = reload register |
| wr_data | input | 16 | Write data |
| cnt_ce | input | 1 | Counter clock enable |
| spk_out | output | 1 | Speaker drive bit |

## Verification
The bench checks where the tone lands with respect to a gate-raising write. A design that counts on the same edge as the restart, or that skips the restart, shifts every later edge by one tick. It writes a new reload value in the middle of a half-period; a design that loads the value at once cuts that half-period short. It runs with `cnt_ce` low on alternate cycles, which exposes a counter that ignores the enable. It runs a full 65536-tick half-period from a reload of 0, where a design that treats 0 literally toggles at once or wraps. Enable toggling and gate drops during a running tone show whether the output stays the AND of the tone and the enable, and whether the tone returns high when the gate falls.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;
  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_RELOAD = 1'b1
  } spk_sel_e;

  localparam int CTRL_GATE_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
endpackage

// File: rtl/spk_rst_sync.sv
`timescale 1ns/1ps
module spk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spk_regs.sv
`timescale 1ns/1ps
module spk_regs
  import spk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             gate,
  output logic             spk_en,
  output logic             restart,
  output logic [CNT_W-1:0] reload
);
  logic             gate_d, en_d, restart_d;
  logic [CNT_W-1:0] reload_d;
  logic             ctrl_wr, reload_wr;

  assign ctrl_wr   = wr_en && (spk_sel_e'(wr_sel) == SEL_CTRL);
  assign reload_wr = wr_en && (spk_sel_e'(wr_sel) == SEL_RELOAD);

  always_comb begin
    gate_d    = gate;
    en_d      = spk_en;
    reload_d  = reload;
    restart_d = 1'b0;
    if (ctrl_wr) begin
      gate_d    = wr_data[CTRL_GATE_BIT];
      en_d      = wr_data[CTRL_EN_BIT];
      restart_d = wr_data[CTRL_GATE_BIT] && !gate;
    end
    if (reload_wr) reload_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate    <= 1'b0;
      spk_en  <= 1'b0;
      restart <= 1'b0;
      reload  <= '0;
    end else begin
      gate    <= gate_d;
      spk_en  <= en_d;
      restart <= restart_d;
      reload  <= reload_d;
    end
  end

  // R8: the reload register moves only on a reload write
  a_r8_reload_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reload != $past(reload)) |-> $past(wr_en && wr_sel == SEL_RELOAD));

  // R5: a restart only follows a low-to-high gate transition
  a_r5_restart_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (gate && !$past(gate)));
endmodule

// File: rtl/spk_div.sv
`timescale 1ns/1ps
module spk_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ce,
  input  logic             gate,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             tone
);
  localparam int            CW       = CNT_W + 1;
  localparam logic [CW-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] ONE_CNT  = {{CNT_W{1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d, reload_eff;
  logic          tone_d;

  assign reload_eff = (reload == '0) ? FULL_CNT : {1'b0, reload};

  always_comb begin
    cnt_d  = cnt_q;
    tone_d = tone;
    if (!gate) begin
      tone_d = 1'b1;
    end else if (restart) begin
      cnt_d  = reload_eff;
      tone_d = 1'b1;
    end else if (cnt_ce) begin
      if (cnt_q == ONE_CNT) begin
        cnt_d  = reload_eff;
        tone_d = ~tone;
      end else begin
        cnt_d = cnt_q - ONE_CNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE_CNT;
      tone  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      tone  <= tone_d;
    end
  end

  // R4: gate low forces the tone high at the next edge
  a_r4_gate_low_tone_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> tone);

  // R4: gate low freezes the count
  a_r4_gate_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> $stable(cnt_q));

  // R5: restart loads the reload value and raises the tone
  a_r5_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && restart) |=> (cnt_q == $past(reload_eff)) && tone);

  // R7: no enable, no movement
  a_r7_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !restart && !cnt_ce) |=> ($stable(cnt_q) && $stable(tone)));

  // R6: the tone only toggles at terminal count
  a_r6_toggle_only_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !restart && cnt_ce && cnt_q != ONE_CNT) |=> $stable(tone));

  // R9: the count never reaches zero and never exceeds the full range
  a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= FULL_CNT));
endmodule

// File: rtl/spk_tone_ctrl.sv
`timescale 1ns/1ps
module spk_tone_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_ce,
  output logic             spk_out
);
  logic             rst_int_n;
  logic             gate, spk_en, restart, tone;
  logic [CNT_W-1:0] reload;

  spk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  spk_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .gate    (gate),
    .spk_en  (spk_en),
    .restart (restart),
    .reload  (reload)
  );

  spk_div #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cnt_ce  (cnt_ce),
    .gate    (gate),
    .restart (restart),
    .reload  (reload),
    .tone    (tone)
  );

  assign spk_out = tone & spk_en;

  // R10: with the gate low the enable bit alone sets the speaker
  a_r10_direct_when_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!gate && !$past(gate)) |-> (spk_out == spk_en));
endmodule

// File: tb/spk_tone_ctrl_bench.sv
`timescale 1ns/1ps
module spk_tone_ctrl_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n, wr_en, wr_sel, cnt_ce;
  logic [CNT_W-1:0] wr_data;
  logic             spk_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  bit    q_exp[$];
  string q_tag[$];
  string cur_tag = "R1";

  bit m_gate = 0, m_en = 0, m_restart = 0, m_tone = 1;
  int m_reload = 0, m_cnt = 1;

  always #2 clk = ~clk;

  spk_tone_ctrl #(.CNT_W(CNT_W)) u_spk_tone_ctrl (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .cnt_ce (cnt_ce), .spk_out (spk_out)
  );

  function automatic int eff(int r);
    return (r == 0) ? 65536 : r;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected speaker bit
  task automatic step(bit we, bit sel, int d, bit ce);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d[CNT_W-1:0]; cnt_ce = ce;
    @(posedge clk);
    if (!m_gate) m_tone = 1;
    else if (m_restart) begin m_cnt = eff(m_reload); m_tone = 1; end
    else if (ce) begin
      if (m_cnt == 1) begin m_tone = !m_tone; m_cnt = eff(m_reload); end
      else m_cnt = m_cnt - 1;
    end
    if (we && !sel) begin
      m_restart = d[0] && !m_gate;
      m_gate = d[0];
      m_en   = d[1];
    end else m_restart = 0;
    if (we && sel) m_reload = d & 32'hFFFF;
    q_exp.push_back(m_tone & m_en);
    q_tag.push_back(cur_tag);
  endtask

  // monitor: compares the design output against the scoreboard
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      bit    e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if (spk_out !== e) begin
        n_bad++;
        $display("FAIL %s: spk_out=%b expected %b at %0t", t, spk_out, e, $time);
      end
    end
  end

  initial begin
    #(4 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_up();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = '0; cnt_ce = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (spk_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: spk_out=%b expected 0 after reset", spk_out);
    end
    // R1: enable only, tone is high
    cur_tag = "R1"; step(1, 0, 2, 0); step(0, 0, 0, 0);
    // R2: direct pulse train via the enable bit
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) begin step(1, 0, (i % 2) ? 2 : 0, 0); step(0, 0, 0, 1); end
    step(1, 1, 3, 0);
    // R5: gate rise arms restart, R6: steady square wave with N=3
    cur_tag = "R5"; step(1, 0, 3, 1);
    cur_tag = "R6"; repeat (20) step(0, 0, 0, 1);
    // R7: enable on alternate cycles
    cur_tag = "R7";
    for (int i = 0; i < 16; i++) step(0, 0, 0, i % 2);
    // R8: reload written mid half-period
    cur_tag = "R8"; step(0, 0, 0, 1); step(1, 1, 5, 1); repeat (30) step(0, 0, 0, 1);
    // R4: gate drop holds tone high
    cur_tag = "R4"; step(1, 0, 2, 1); repeat (6) step(0, 0, 0, 1);
    cur_tag = "R5"; step(1, 0, 3, 1); repeat (12) step(0, 0, 0, 1);
    // R3: enable clear while timer runs
    cur_tag = "R3"; step(1, 0, 1, 1); repeat (10) step(0, 0, 0, 1);
    // R10: enable toggling and gate modulation together
    cur_tag = "R10";
    for (int i = 0; i < 8; i++) begin
      step(1, 0, (i % 3 == 0) ? 2 : 3, 1);
      step(0, 0, 0, 1);
      step(1, 0, (i % 2) ? 1 : 3, 1);
      repeat (3) step(0, 0, 0, i % 2);
    end
    // R9: reload of zero gives a 65536-tick half-period
    cur_tag = "R9";
    step(1, 1, 0, 1); step(1, 0, 2, 1); step(1, 0, 3, 1);
    repeat (65540) step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    finish_up();
  end
endmodule